// File: doc/BRIEF.md
# Pixel Sync Pulse Generator

This block produces the internal per-pixel sync pulse that paces the video sampling sequence of a scanner front end. In direct mode the external sync pin is forwarded to the timing logic unchanged, apart from a fixed synchronizer latency. In detect mode any clock-like signal running at the pixel rate can drive the sync pin. The block picks out either its rising or its falling edges. For each chosen edge it emits a pulse one clock wide, placed 0 to 7 clock periods after the edge.

From the pulse the block derives three further timing outputs. The first is the sample strobe, which marks the clock edge on which the video level is captured. The second is a reset-level strobe, which can be moved one cycle earlier or up to two cycles later. The third is a clamp strobe. It shares the reset strobe's timing and only appears when the clamp request input was high while the sync pulse was active.

Top module: `pixel_sync_gen`

## Requirements
- R1: With `detEn` = 0, `intPulse` equals `syncPin` delayed by exactly 3 clock edges (two synchronizer flops plus one output register), whatever the values of `risingSel` and `delaySel`.
- R2: With `detEn` = 1, `risingSel` = 1 picks rising edges of `syncPin` and `risingSel` = 0 picks falling edges. An edge of the other direction produces no pulse.
- R3: In detect mode each picked edge yields a pulse on `intPulse` exactly one cycle wide. It appears 3 + `delaySel` cycles after the pin change, with `delaySel` taken as an unsigned count from 0 to 7.
- R4: `sampleStrobe` is high for exactly the one cycle that directly follows the last cycle of an `intPulse` pulse, so the next rising clock edge captures the video sample.
- R5: `clampReq` is sampled on each rising clock edge at which `intPulse` is high. The last value sampled decides whether `clampStrobe` copies the next `refStrobe` (1) or stays low (0). Values of `clampReq` outside the pulse have no effect.
- R6: `refStrobe` comes RST_LAG + s cycles after `sampleStrobe` (default RST_LAG = 3). The shift s is -1, 0, +1 or +2 for `refPos` = 2'b00, 2'b01, 2'b10 and 2'b11.
- R7: If a picked edge arrives while a delayed pulse is still pending, the pending pulse is dropped. Only the newer edge produces a pulse, with its own delay.
- R8: After reset all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncPin | input | 1 | External sync or pixel-rate clock, asynchronous |
| detEn | input | 1 | 1 = edge detect mode, 0 = direct forwarding |
| risingSel | input | 1 | Edge choice in detect mode: 1 rising, 0 falling |
| delaySel | input | DELAY_W (3) | Pulse delay after the edge, in clock cycles |
| clampReq | input | 1 | Clamp request, sampled during the sync pulse |
| refPos | input | POS_W (2) | Reset strobe shift: 00 early, 01 nominal, 10 late, 11 two late |
| intPulse | output | 1 | Internal sync pulse |
| sampleStrobe | output | 1 | Video sample strobe |
| refStrobe | output | 1 | Reset-level sample strobe |
| clampStrobe | output | 1 | Clamp strobe on the reset level |

## Verification
A pin change driven between two clock edges shows up on `intPulse` 3 + `delaySel` cycles later. `sampleStrobe` follows one cycle after the pulse, and `refStrobe` and `clampStrobe` follow RST_LAG + `refPos` cycles after the pulse. Each scenario drives its inputs at falling clock edges and records all four outputs at every falling edge of a window into bit vectors. It then compares each vector with one built from these offsets, so a value that comes a cycle early, a cycle late or twice is caught directly. Windows are separated by idle stretches that are longer than the maximum delay plus the reset strobe history. This keeps a pulse pending from an earlier scenario out of the next window.

// File: rtl/sync_gen_pkg.sv
package sync_gen_pkg;
  // strobes handed from the control to the datapath
  typedef struct packed {
    logic pulse;     // internal sync pulse
    logic pulseEnd;  // first cycle after a pulse ended
  } syncStrobe_t;
endpackage

// File: rtl/sync_pulse_ctrl.sv
module sync_pulse_ctrl
  import sync_gen_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DELAY_W     = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               syncPin,
  input  logic               detEn,
  input  logic               risingSel,
  input  logic [DELAY_W-1:0] delaySel,
  output syncStrobe_t        strobes
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic syncNow, syncPrev, edgeHit;
  logic pendQ, pulseQ, prevPulseQ;
  logic [DELAY_W-1:0] cntQ;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], syncPin};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= syncPin;
      end
    end
  endgenerate

  assign syncNow = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPrev <= 1'b0;
    else       syncPrev <= syncNow;
  end

  always_comb begin
    if (risingSel) edgeHit = syncNow & ~syncPrev;
    else           edgeHit = ~syncNow & syncPrev;
  end

  // one register carries both paths, so the latencies match
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseQ     <= 1'b0;
      prevPulseQ <= 1'b0;
      pendQ      <= 1'b0;
      cntQ       <= '0;
    end else begin
      prevPulseQ <= pulseQ;
      if (!detEn) begin
        pulseQ <= syncNow;
        pendQ  <= 1'b0;
        cntQ   <= '0;
      end else if (edgeHit) begin
        // a new edge always replaces whatever is pending
        if (delaySel == '0) begin
          pulseQ <= 1'b1;
          pendQ  <= 1'b0;
        end else begin
          pulseQ <= 1'b0;
          pendQ  <= 1'b1;
          cntQ   <= delaySel - 1'b1;
        end
      end else if (pendQ && cntQ == '0) begin
        pulseQ <= 1'b1;
        pendQ  <= 1'b0;
      end else begin
        pulseQ <= 1'b0;
        if (pendQ) cntQ <= cntQ - 1'b1;
      end
    end
  end

  assign strobes.pulse    = pulseQ;
  assign strobes.pulseEnd = prevPulseQ & ~pulseQ;
endmodule

// File: rtl/sync_pulse_dp.sv
module sync_pulse_dp
  import sync_gen_pkg::*;
#(
  parameter int RST_LAG = 3,
  parameter int POS_W   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  syncStrobe_t      strobes,
  input  logic             clampReq,
  input  logic [POS_W-1:0] refPos,
  output logic             intPulse,
  output logic             sampleStrobe,
  output logic             refStrobe,
  output logic             clampStrobe
);
  localparam int HIST_D = RST_LAG - 1 + (1 << POS_W);
  localparam int IDX_W  = $clog2(HIST_D);

  logic [HIST_D-1:0] hist;
  logic [IDX_W-1:0]  tapIdx;
  logic              clampArm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hist <= '0;
    else       hist <= {hist[HIST_D-2:0], strobes.pulseEnd};
  end

  // hist[k] is the sample strobe delayed by k+1 cycles
  assign tapIdx = IDX_W'(RST_LAG - 2) + IDX_W'(refPos);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              clampArm <= 1'b0;
    else if (strobes.pulse) clampArm <= clampReq;
  end

  assign intPulse     = strobes.pulse;
  assign sampleStrobe = strobes.pulseEnd;
  assign refStrobe    = hist[tapIdx];
  assign clampStrobe  = hist[tapIdx] & clampArm;
endmodule

// File: rtl/pixel_sync_gen.sv
module pixel_sync_gen
  import sync_gen_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DELAY_W     = 3,
  parameter int POS_W       = 2,
  parameter int RST_LAG     = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               syncPin,
  input  logic               detEn,
  input  logic               risingSel,
  input  logic [DELAY_W-1:0] delaySel,
  input  logic               clampReq,
  input  logic [POS_W-1:0]   refPos,
  output logic               intPulse,
  output logic               sampleStrobe,
  output logic               refStrobe,
  output logic               clampStrobe
);
  syncStrobe_t strobes;

  sync_pulse_ctrl #(.SYNC_STAGES(SYNC_STAGES), .DELAY_W(DELAY_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .syncPin(syncPin), .detEn(detEn),
    .risingSel(risingSel), .delaySel(delaySel), .strobes(strobes)
  );

  sync_pulse_dp #(.RST_LAG(RST_LAG), .POS_W(POS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .clampReq(clampReq),
    .refPos(refPos), .intPulse(intPulse), .sampleStrobe(sampleStrobe),
    .refStrobe(refStrobe), .clampStrobe(clampStrobe)
  );
endmodule

// File: rtl/pixel_sync_gen_chk.sv
module pixel_sync_gen_chk #(
  parameter int SYNC_STAGES = 2,
  parameter int DELAY_W     = 3,
  parameter int POS_W       = 2,
  parameter int RST_LAG     = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               syncPin,
  input logic               detEn,
  input logic               risingSel,
  input logic [DELAY_W-1:0] delaySel,
  input logic               clampReq,
  input logic [POS_W-1:0]   refPos,
  input logic               intPulse,
  input logic               sampleStrobe,
  input logic               refStrobe,
  input logic               clampStrobe
);
  localparam int HIST_D = RST_LAG - 1 + (1 << POS_W);

  logic [7:0] upCnt, sinceSmp, posAge;
  logic [POS_W-1:0] lastPos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upCnt    <= '0;
      sinceSmp <= 8'hFF;
      posAge   <= '0;
      lastPos  <= '0;
    end else begin
      if (upCnt != 8'hFF) upCnt <= upCnt + 1'b1;
      if (sampleStrobe)             sinceSmp <= 8'd1;
      else if (sinceSmp != 8'hFF)   sinceSmp <= sinceSmp + 1'b1;
      lastPos <= refPos;
      if (refPos != lastPos)        posAge <= '0;
      else if (posAge != 8'hFF)     posAge <= posAge + 1'b1;
    end
  end

  generate
    if (SYNC_STAGES == 2) begin : g_lat
      // R1: forwarding mode keeps a 3-edge latency
      p_pass_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
        (upCnt >= 8'd4 && !$past(detEn)) |-> (intPulse == $past(syncPin, 3)));

      // R2: a chosen edge with zero delay always yields a pulse
      p_edge_pick_r2: assert property (@(posedge clk) disable iff (!rstN)
        (upCnt >= 8'd5 && $past(detEn) && $past(delaySel) == '0 &&
         $past(syncPin, 3) != $past(syncPin, 4) &&
         $past(syncPin, 3) == $past(risingSel)) |-> intPulse);
    end
  endgenerate

  // R4: the end of every pulse brings a sample strobe
  p_sample_after_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intPulse) |-> sampleStrobe);

  // R5: a low request captured during the pulse blocks the clamp
  p_clamp_block_r5: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 8'd1 && $past(intPulse) && !$past(clampReq)) |-> !clampStrobe);

  // R6: reset strobe offset from the sample strobe
  p_ref_offset_r6: assert property (@(posedge clk) disable iff (!rstN)
    (refStrobe && posAge >= 8'(HIST_D)) |->
      (sinceSmp == 8'(RST_LAG - 1) + 8'(refPos)));
endmodule

bind pixel_sync_gen pixel_sync_gen_chk #(
  .SYNC_STAGES(SYNC_STAGES), .DELAY_W(DELAY_W), .POS_W(POS_W), .RST_LAG(RST_LAG)
) u_chk (
  .clk(clk), .rstN(rstN), .syncPin(syncPin), .detEn(detEn),
  .risingSel(risingSel), .delaySel(delaySel), .clampReq(clampReq),
  .refPos(refPos), .intPulse(intPulse), .sampleStrobe(sampleStrobe),
  .refStrobe(refStrobe), .clampStrobe(clampStrobe)
);

// File: tb/tb_pixel_sync_gen.sv
module tb_pixel_sync_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       syncPin = 1'b0;
  logic       detEn = 1'b0;
  logic       risingSel = 1'b1;
  logic [2:0] delaySel = 3'd0;
  logic       clampReq = 1'b0;
  logic [1:0] refPos = 2'b01;
  logic       intPulse, sampleStrobe, refStrobe, clampStrobe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] recPulse, recSmp, recRef, recClamp;

  always #10 clk = ~clk;

  pixel_sync_gen dut (
    .clk(clk), .rstN(rstN), .syncPin(syncPin), .detEn(detEn),
    .risingSel(risingSel), .delaySel(delaySel), .clampReq(clampReq),
    .refPos(refPos), .intPulse(intPulse), .sampleStrobe(sampleStrobe),
    .refStrobe(refStrobe), .clampStrobe(clampStrobe)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      syncPin  = 1'b0;
      clampReq = 1'b0;
    end
  endtask

  // record outputs, then drive the next pattern bit, at each falling edge
  task automatic runWin(input logic [31:0] pinPat, input logic [31:0] clPat, input int len);
    recPulse = '0; recSmp = '0; recRef = '0; recClamp = '0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      recPulse[i] = intPulse;
      recSmp[i]   = sampleStrobe;
      recRef[i]   = refStrobe;
      recClamp[i] = clampStrobe;
      syncPin  = pinPat[i];
      clampReq = clPat[i];
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R8 intPulse after reset", 32'(intPulse), 32'd0);
    check("R8 sampleStrobe after reset", 32'(sampleStrobe), 32'd0);
    check("R8 refStrobe after reset", 32'(refStrobe), 32'd0);
    check("R8 clampStrobe after reset", 32'(clampStrobe), 32'd0);
  endtask

  task automatic t_pass(input logic pol, input logic [2:0] dly);
    logic [31:0] pat;
    pat = 32'h0000_100F;
    detEn = 1'b0; risingSel = pol; delaySel = dly;
    idle(12);
    runWin(pat, 32'd0, 24);
    check("R1 forwarded pulse shape", recPulse, (pat << 3) & 32'h00FF_FFFF);
    check("R4 strobe after forwarded pulse", recSmp, (32'd1 << 7) | (32'd1 << 16));
  endtask

  task automatic t_detect(input logic pol, input logic [2:0] dly);
    int edgeAt, p;
    edgeAt = pol ? 2 : 10;
    p = edgeAt + 3 + int'(dly);
    detEn = 1'b1; risingSel = pol; delaySel = dly;
    idle(12);
    runWin(32'h0000_03FC, 32'd0, 24);
    check(pol ? "R2 R3 rising edge pulse" : "R2 R3 falling edge pulse",
          recPulse, 32'd1 << p);
    check("R4 strobe after detected pulse", recSmp, 32'd1 << (p + 1));
  endtask

  task automatic t_ref(input logic [1:0] pos);
    detEn = 1'b1; risingSel = 1'b1; delaySel = 3'd0; refPos = pos;
    idle(12);
    // pulse at 5, clamp requested only during it
    runWin(32'h0000_03FC, 32'd1 << 5, 20);
    check("R6 reset strobe position", recRef, 32'd1 << (8 + int'(pos)));
    check("R5 clamp follows reset strobe", recClamp, 32'd1 << (8 + int'(pos)));
  endtask

  task automatic t_clampOff();
    detEn = 1'b1; risingSel = 1'b1; delaySel = 3'd0; refPos = 2'b01;
    idle(12);
    runWin(32'h0000_03FC, ~(32'd1 << 5), 20);
    check("R5 clamp blocked by low request", recClamp, 32'd0);
    check("R6 reset strobe still present", recRef, 32'd1 << 9);
  endtask

  task automatic t_replace();
    detEn = 1'b1; risingSel = 1'b1; delaySel = 3'd7;
    idle(14);
    runWin(32'hFFFF_FFF3, 32'd0, 24);
    check("R7 pending pulse replaced", recPulse, 32'd1 << 14);
    idle(14);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_pass(1'b1, 3'd5);
    t_pass(1'b0, 3'd0);
    t_detect(1'b1, 3'd0);
    t_detect(1'b0, 3'd3);
    t_detect(1'b1, 3'd7);
    for (int k = 0; k < 4; k++) t_ref(2'(k));
    t_clampOff();
    t_replace();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule